// File: doc/BRIEF.md
# DMA Slave Handshake Controller

This block is the peripheral end of a DMA handshake on a 16-bit parallel bus. Firmware programs a byte count and a configuration word through a small register port, then starts the transfer. The block raises a request line. For each word the host answers by pulling its acknowledge low and, in the same cycle, pulling a read or write strobe low. On a write strobe the bus word is handed to the local sink. On a read strobe the local source word is driven onto the bus. An acknowledge without a strobe moves nothing.

The transfer stops in one of two ways, chosen by a configuration bit. The first is an active-low end-of-transfer input, which passes through a synchronizer. The second is an internal byte counter. It adds two for every word and stops the transfer when it equals the programmed count. The request line can drop after every word (single-cycle mode) or stay up for a fixed burst of words (burst mode). When the transfer ends, the request drops at once and a sticky done flag is set. Firmware reads the flag and clears it by writing.

The handshake controller has four states. ST_IDLE is the state after reset. ST_REQ holds the request high. ST_GAP holds the request low for one cycle between requests. ST_DONE is the terminated state. A registered start command moves any state to ST_REQ, or straight to ST_DONE when the internal counter is selected and the count is zero. ST_REQ goes to ST_DONE on the end condition, goes to ST_GAP when a word closes a request window, and otherwise stays in ST_REQ. ST_GAP goes to ST_DONE on an external end condition and otherwise returns to ST_REQ. ST_DONE and ST_IDLE stay where they are until a start command arrives.

Top module: `dma_slave_hs`

## Requirements
- R1: After reset `dreq` and `done` are 0, and the configuration, count and status registers read 0.
- R2: Register access happens when `reg_sel` is 1. Address bit 7 set means write and clear means read. The low seven bits select the register: 0x21 is configuration (bit 0 start, bit 1 internal-counter select, bit 2 burst mode; only bits 2:0 are kept), 0x22 is the byte count, and 0x23 is status (bit 0 done). Unmapped addresses read 0, and `reg_rdata` follows `reg_addr` combinationally.
- R3: A word moves only while `dreq` is 1 and `dack_n` is 0. If `wr_n` is 0, `push_valid` is 1 and `push_data` equals `dma_din`. If `rd_n` is 0 and `wr_n` is 1, `pop_ack` and `dma_doe` are 1 and `dma_dout` equals `pop_data`.
- R4: In single-cycle mode (burst bit 0), `dreq` is 0 in the cycle after each word that does not end the transfer, and it is 1 again in the cycle after that.
- R5: In burst mode, `dreq` stays 1 across the first BURST_LEN-1 words of each window (default 4 words) and drops for one cycle after the last word of the window.
- R6: With the internal counter selected, the byte counter is cleared on start and adds 2 per word. The transfer ends on the word that makes the counter equal the byte count, which is after count/2 words for an even count.
- R7: With the internal counter not selected, a low level on `eot_n` ends the transfer by the third rising edge after it is applied.
- R8: At the end of a transfer, `dreq` falls on the same edge that sets `done`. `done` stays 1 and reads as status bit 0. It is cleared by a write to 0x23 (address 0xA3) or by the next start.
- R9: After the end of a transfer, acknowledge and strobes produce no `push_valid` or `pop_ack`.
- R10: With the internal counter selected and a byte count of 0, a start sets `done` without ever raising `dreq`.
- R11: With the internal counter selected, `eot_n` has no effect: `dreq` stays 1 and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_addr | input | 8 | Register address; bit 7 set for write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| dreq | output | 1 | DMA request, active high |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| eot_n | input | 1 | External end of transfer, active low, asynchronous |
| dma_din | input | DW | Bus data from host |
| dma_dout | output | DW | Bus data to host |
| dma_doe | output | 1 | Bus output enable |
| push_valid | output | 1 | A host-written word is valid on push_data |
| push_data | output | DW | Word written by the host |
| pop_data | input | DW | Word offered for a host read |
| pop_ack | output | 1 | pop_data was taken by a host read |
| done | output | 1 | Sticky end-of-transfer flag |

## Verification
The assertions assume that the host never asserts a strobe without also holding `dack_n` low, and that firmware does not issue a new start while a word is being transferred. They also assume the programmed byte count is even whenever the internal counter is selected. The bench keeps to these rules. It starts transfers only from a quiet bus, programs only even counts, and applies each acknowledge and strobe pair for exactly one cycle once it has seen `dreq` high. The only exception is the deliberate late strobes applied after termination.

// File: rtl/dmahs_pkg.sv
`timescale 1ns/1ps
package dmahs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_GAP,
        ST_DONE
    } hs_state_t;

    localparam logic [6:0] ADDR_CFG  = 7'h21;
    localparam logic [6:0] ADDR_CNT  = 7'h22;
    localparam logic [6:0] ADDR_STAT = 7'h23;

    localparam int CFG_START = 0;
    localparam int CFG_ISEL  = 1;
    localparam int CFG_BURST = 2;
endpackage

// File: rtl/dmahs_regs.sv
`timescale 1ns/1ps
module dmahs_regs
    import dmahs_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          done_set,
    output logic [DW-1:0] reg_rdata,
    output logic          cnt_sel,
    output logic          burst_mode,
    output logic [CW-1:0] xfer_cnt,
    output logic          start_q,
    output logic          done
);
    logic       is_wr;
    logic [6:0] idx;
    logic [2:0] cfg;
    logic       unused_wbits;

    assign is_wr        = reg_sel && reg_addr[7];
    assign idx          = reg_addr[6:0];
    assign cnt_sel      = cfg[CFG_ISEL];
    assign burst_mode   = cfg[CFG_BURST];
    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            xfer_cnt <= '0;
            start_q  <= 1'b0;
            done     <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (is_wr && idx == ADDR_CFG) begin
                cfg     <= reg_wdata[2:0];
                start_q <= reg_wdata[CFG_START];
            end
            if (is_wr && idx == ADDR_CNT) begin
                xfer_cnt <= reg_wdata[CW-1:0];
            end
            if (done_set) begin
                done <= 1'b1;
            end else if (start_q || (is_wr && idx == ADDR_STAT)) begin
                done <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (idx)
            ADDR_CFG:  reg_rdata[2:0] = cfg;
            ADDR_CNT:  reg_rdata      = DW'(xfer_cnt);
            ADDR_STAT: reg_rdata[0]   = done;
            default:   reg_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/dmahs_sync.sv
`timescale 1ns/1ps
module dmahs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_n};
        end
    end

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/dmahs_fsm.sv
`timescale 1ns/1ps
module dmahs_fsm
    import dmahs_pkg::*;
#(
    parameter int CW        = 16,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cnt_sel,
    input  logic          burst_mode,
    input  logic [CW-1:0] xfer_cnt,
    input  logic          eot_ext,
    input  logic          word_any,
    output logic          dreq,
    output logic          take,
    output logic          done_set
);
    localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(BURST_LEN - 1);

    hs_state_t     state, nxt;
    logic [CW-1:0] byte_cnt, byte_nx;
    logic [BW-1:0] beat;
    logic          hit, win_end, ext_end;

    assign take    = (state == ST_REQ) && word_any;
    assign byte_nx = byte_cnt + CW'(2);
    assign hit     = cnt_sel && take && (byte_nx == xfer_cnt);
    assign win_end = !burst_mode || (beat == LAST_BEAT);
    assign ext_end = !cnt_sel && eot_ext && (state == ST_REQ || state == ST_GAP);

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = (cnt_sel && xfer_cnt == '0) ? ST_DONE : ST_REQ;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_REQ: begin
                    if (ext_end || hit)      nxt = ST_DONE;
                    else if (take && win_end) nxt = ST_GAP;
                    else                     nxt = ST_REQ;
                end
                ST_GAP:  nxt = ext_end ? ST_DONE : ST_REQ;
                ST_DONE: nxt = ST_DONE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            beat     <= '0;
        end else if (start) begin
            byte_cnt <= '0;
            beat     <= '0;
        end else if (take) begin
            byte_cnt <= byte_nx;
            beat     <= win_end ? '0 : beat + BW'(1);
        end
    end

    always_comb begin
        dreq     = (state == ST_REQ);
        done_set = (nxt == ST_DONE) && (state != ST_DONE || start);
    end
endmodule

// File: rtl/dma_slave_hs.sv
`timescale 1ns/1ps
module dma_slave_hs #(
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int BURST_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          dreq,
    input  logic          dack_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          eot_n,
    input  logic [DW-1:0] dma_din,
    output logic [DW-1:0] dma_dout,
    output logic          dma_doe,
    output logic          push_valid,
    output logic [DW-1:0] push_data,
    input  logic [DW-1:0] pop_data,
    output logic          pop_ack,
    output logic          done
);
    logic          cnt_sel, burst_mode, start_q, done_set;
    logic [CW-1:0] xfer_cnt;
    logic          eot_sync_n, word_any, take;

    dmahs_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .done_set   (done_set),
        .reg_rdata  (reg_rdata),
        .cnt_sel    (cnt_sel),
        .burst_mode (burst_mode),
        .xfer_cnt   (xfer_cnt),
        .start_q    (start_q),
        .done       (done)
    );

    dmahs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (eot_n),
        .sync_n  (eot_sync_n)
    );

    assign word_any = !dack_n && (!rd_n || !wr_n);

    dmahs_fsm #(.CW(CW), .BURST_LEN(BURST_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_q),
        .cnt_sel    (cnt_sel),
        .burst_mode (burst_mode),
        .xfer_cnt   (xfer_cnt),
        .eot_ext    (!eot_sync_n),
        .word_any   (word_any),
        .dreq       (dreq),
        .take       (take),
        .done_set   (done_set)
    );

    assign push_valid = take && !wr_n;
    assign push_data  = dma_din;
    assign pop_ack    = take && !rd_n && wr_n;
    assign dma_doe    = pop_ack;
    assign dma_dout   = pop_data;
endmodule

// File: rtl/dmahs_chk.sv
`timescale 1ns/1ps
module dmahs_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dreq,
    input logic          dack_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          push_valid,
    input logic          pop_ack,
    input logic          done,
    input logic          burst_mode,
    input logic          cnt_sel,
    input logic          start_q,
    input logic [CW-1:0] xfer_cnt
);
    assert_push_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (dreq && !dack_n && !wr_n));

    assert_pop_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ack |-> (dreq && !dack_n && !rd_n));

    assert_single_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_valid || pop_ack) && !burst_mode && !start_q) |=> !dreq);

    assert_no_req_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dreq);

    assert_ignore_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!push_valid && !pop_ack));

    assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && cnt_sel && xfer_cnt == '0) |=> (done && !dreq));

    assert_pin_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sel && !start_q && !push_valid && !pop_ack && !done) |=> !done);
endmodule

bind dma_slave_hs dmahs_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .dack_n     (dack_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .push_valid (push_valid),
    .pop_ack    (pop_ack),
    .done       (done),
    .burst_mode (burst_mode),
    .cnt_sel    (cnt_sel),
    .start_q    (start_q),
    .xfer_cnt   (xfer_cnt)
);

// File: tb/sim_dma_slave_hs.sv
`timescale 1ns/1ps
module sim_dma_slave_hs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dreq;
    logic        dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eot_n = 1'b1;
    logic [15:0] dma_din = '0, pop_data = '0;
    logic [15:0] dma_dout, push_data;
    logic        dma_doe, push_valid, pop_ack, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_slave_hs u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n), .eot_n(eot_n),
        .dma_din(dma_din), .dma_dout(dma_dout), .dma_doe(dma_doe),
        .push_valid(push_valid), .push_data(push_data), .pop_data(pop_data),
        .pop_ack(pop_ack), .done(done)
    );

    // {is_write, address, write data, expected read data}
    localparam logic [40:0] VEC [0:5] = '{
        {1'b1, 8'hA2, 16'h0006, 16'h0000},
        {1'b0, 8'h22, 16'h0000, 16'h0006},
        {1'b1, 8'hA1, 16'h00F6, 16'h0000},
        {1'b0, 8'h21, 16'h0000, 16'h0006},
        {1'b0, 8'h23, 16'h0000, 16'h0000},
        {1'b0, 8'h35, 16'h0000, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
        reg_sel = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, input logic [15:0] exp, input string req);
        reg_sel = 1'b1; reg_addr = a;
        #1;
        chk(req, 32'(reg_rdata), 32'(exp));
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic xfer(input bit is_rd, input logic [15:0] d, input string req);
        int n = 0;
        while (!dreq && n < 50) begin
            @(negedge clk);
            n++;
        end
        dack_n = 1'b0;
        if (is_rd) begin rd_n = 1'b0; pop_data = d; end
        else       begin wr_n = 1'b0; dma_din  = d; end
        #1;
        if (is_rd) begin
            chk(req, 32'(pop_ack), 1);
            chk(req, 32'(dma_dout), 32'(d));
            chk(req, 32'(dma_doe), 1);
        end else begin
            chk(req, 32'(push_valid), 1);
            chk(req, 32'(push_data), 32'(d));
        end
        @(negedge clk);
        dack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 dreq", 32'(dreq), 0);
        chk("R1 done", 32'(done), 0);
        reg_rd(8'h21, 16'h0000, "R1 cfg");
        reg_rd(8'h22, 16'h0000, "R1 cnt");

        // R2: register port vectors
        for (int i = 0; i < 6; i++) begin
            if (VEC[i][40]) reg_wr(VEC[i][39:32], VEC[i][31:16]);
            else            reg_rd(VEC[i][39:32], VEC[i][15:0], "R2 regs");
        end

        // R3 R4 R6: single mode, internal count 6 -> 3 words
        reg_wr(8'hA2, 16'h0006);
        reg_wr(8'hA1, 16'h0003);
        @(negedge clk);
        chk("R6 dreq after start", 32'(dreq), 1);
        xfer(1'b0, 16'hA5A1, "R3 write word");
        chk("R4 gap", 32'(dreq), 0);
        @(negedge clk);
        chk("R4 re-request", 32'(dreq), 1);
        xfer(1'b1, 16'h3C5A, "R3 read word");
        chk("R4 gap 2", 32'(dreq), 0);
        // R3: acknowledge without strobe moves nothing
        @(negedge clk);
        dack_n = 1'b0;
        #1;
        chk("R3 dack alone push", 32'(push_valid), 0);
        chk("R3 dack alone pop", 32'(pop_ack), 0);
        @(negedge clk);
        dack_n = 1'b1;
        chk("R3 still requesting", 32'(dreq), 1);
        xfer(1'b0, 16'h1234, "R3 last word");
        chk("R6 end after count", 32'(done), 1);
        chk("R8 dreq low at end", 32'(dreq), 0);

        // R8: sticky flag, readable, cleared on write
        repeat (3) @(negedge clk);
        chk("R8 sticky", 32'(done), 1);
        reg_rd(8'h23, 16'h0001, "R8 status read");
        reg_wr(8'hA3, 16'h0000);
        reg_rd(8'h23, 16'h0000, "R8 status clear");

        // R5 R6: burst mode, count 16 -> 8 words, counter restarted
        reg_wr(8'hA2, 16'h0010);
        reg_wr(8'hA1, 16'h0007);
        for (int w = 0; w < 8; w++) begin
            xfer(1'b0, 16'(w + 16'h100), "R5 burst word");
            if (w == 3)      chk("R5 window end", 32'(dreq), 0);
            else if (w < 7)  chk("R5 held", 32'(dreq), 1);
        end
        chk("R6 burst end", 32'(done), 1);

        // R7 R9: external end of transfer
        reg_wr(8'hA1, 16'h0001);
        xfer(1'b0, 16'h0F0F, "R3 ext word 1");
        xfer(1'b1, 16'hF0F0, "R3 ext word 2");
        chk("R7 not ended", 32'(done), 0);
        eot_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 ext end done", 32'(done), 1);
        chk("R7 ext end dreq", 32'(dreq), 0);
        eot_n = 1'b1;
        dack_n = 1'b0; wr_n = 1'b0;
        #1;
        chk("R9 late write", 32'(push_valid), 0);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        #1;
        chk("R9 late read", 32'(pop_ack), 0);
        @(negedge clk);
        dack_n = 1'b1; rd_n = 1'b1;
        chk("R9 still ended", 32'(dreq), 0);

        // R10: zero count with internal counter
        reg_wr(8'hA2, 16'h0000);
        reg_wr(8'hA1, 16'h0003);
        for (int c = 0; c < 4; c++) begin
            chk("R10 no request", 32'(dreq), 0);
            @(negedge clk);
        end
        chk("R10 done", 32'(done), 1);

        // R11: pin ignored when internal counter selected
        reg_wr(8'hA2, 16'h0004);
        reg_wr(8'hA1, 16'h0003);
        @(negedge clk);
        eot_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 dreq held", 32'(dreq), 1);
        chk("R11 done clear", 32'(done), 0);
        eot_n = 1'b1;
        repeat (3) @(negedge clk);
        xfer(1'b0, 16'h5555, "R11 word 1");
        xfer(1'b0, 16'hAAAA, "R11 word 2");
        chk("R11 count end", 32'(done), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule